// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between an internal single-word request bus and an external 512K x 8 asynchronous static RAM. It turns each accepted read or write request into a sequence of active-low select, read-enable and write-enable strobes. It also drives a data-pin enable for the shared data bus. No timing in the memory is measured. Every analog minimum is met by holding each phase for a whole number of clock cycles. Those counts are derived at elaboration from the clock period and from the nanosecond limits of the speed grade.

A request is presented with `req_valid`, `req_write`, `req_addr` and `req_wdata`. The controller accepts it only while idle. It registers the address and write data at that point and holds them for the whole access. Completion is reported by a one-cycle `req_ready` pulse. On a read, the sampled byte appears on `req_rdata` in that same cycle. The data pins are split into an outgoing value, an incoming value and a drive enable, so the pad ring can build the tri-state buffer.

Top module: `sram_ctl`

## Requirements
- R1: While reset is low and after it is released, the controller is idle with these output levels: select, read-enable and write-enable high, data drive enable low, and ready low.
- R2: A read holds select and read-enable low and write-enable high for exactly RD_CYC cycles, with the data drive enable low throughout. RD_CYC is the larger of the address-access and output-enable access counts, each plus one margin cycle, and is 8 with the default parameters.
- R3: On a read, the byte on `mem_dq_in` in the final cycle of the read window appears on `req_rdata` together with the ready pulse. It stays there until the next read completes.
- R4: During a write, read-enable stays high and select stays low. The data drive enable rises at least one cycle before write-enable falls. The controller never drives the data pins while read-enable is low.
- R5: Write-enable is low for exactly PULSE_CYC cycles. PULSE_CYC is the largest of the write-pulse count, the data-setup count and the select-to-end count less the one setup cycle, and is 5 with the default parameters.
- R6: After write-enable rises, select stays low and the data stays driven for HOLD_CYC cycles, and the drive enable then falls. HOLD_CYC is at least 1 and is stretched so the whole write meets the write-cycle minimum. It is 1 with the default parameters, which gives a 7-cycle write.
- R7: A write that directly follows a read first spends TURN_CYC cycles with select low and the data pins released, and only then drives data. TURN_CYC is the memory's output release time in cycles, minimum 1, and is 3 with the default parameters. A write that follows a write has no such cycles.
- R8: Address and write data are captured when a request is accepted. `mem_addr` and `mem_dq_out` stay constant for the whole access, even if the request inputs change.
- R9: `req_ready` is high for exactly one cycle per completed access, and select is high in that cycle. A request is accepted only while idle with ready low. A request raised and dropped during an access, or still held during the ready cycle, starts no access.
- R10: All 19 address bits reach `mem_addr`, so the lowest and highest addresses of the 512K space are both reachable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address of the request |
| req_wdata | input | DATA_W (8) | Byte to write |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W (8) | Last byte read |
| mem_addr | output | ADDR_W (19) | Address pins of the memory |
| mem_sel_n | output | 1 | Active-low chip select strobe |
| mem_rd_en_n | output | 1 | Active-low output-enable strobe |
| mem_wr_en_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | DATA_W (8) | Value driven onto the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | DATA_W (8) | Value read from the data pins |

## Verification
The bench builds the controller with its default parameters: an 8000 ps clock period and the fastest grade's limits of 40, 25, 45, 55, 55, 25 and 20 ns. These give a 5-cycle write pulse, a 1-cycle hold, an 8-cycle read window and a 3-cycle turnaround. They put every phase boundary within reach of exact cycle counts. The read window is one cycle longer than the 55 ns access time, and the memory model in the bench returns a junk byte until that time has passed. A read window that is one cycle short therefore returns wrong data. The model also keeps its outputs on for three cycles after read-enable rises, so a missing or short turnaround shows up as bus contention.

// File: rtl/sram_ctl_pkg.sv
// Package: shared state encoding, strobe bundle and constant helpers for
// the asynchronous SRAM controller. Assumes strobes are active low.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD     = 3'd1,
        ST_WTURN  = 3'd2,
        ST_WSETUP = 3'd3,
        ST_WPULSE = 3'd4,
        ST_WHOLD  = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic sel_n;
        logic rd_en_n;
        logic wr_en_n;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_IDLE = '{sel_n: 1'b1, rd_en_n: 1'b1, wr_en_n: 1'b1, drive: 1'b0};

    // Whole clock cycles needed to cover a nanosecond minimum (rounded up).
    function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Strobe and drive levels that belong to each sequencer state.
    function automatic pin_ctl_t pins_for(input seq_state_t s);
        pin_ctl_t p;
        p = PINS_IDLE;
        case (s)
            ST_RD:     begin p.sel_n = 1'b0; p.rd_en_n = 1'b0; end
            ST_WTURN:  begin p.sel_n = 1'b0; end
            ST_WSETUP: begin p.sel_n = 1'b0; p.drive = 1'b1; end
            ST_WPULSE: begin p.sel_n = 1'b0; p.drive = 1'b1; p.wr_en_n = 1'b0; end
            ST_WHOLD:  begin p.sel_n = 1'b0; p.drive = 1'b1; end
            default:   p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Module: down-counter that times one sequencer phase.
// Loading N-1 on phase entry makes 'expired' rise in the Nth cycle of the
// phase. Assumes the sequencer reloads it on every phase change.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Reload on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_xfer_regs.sv
// Module: request address/data capture and read-data capture.
// Assumes 'accept' and 'capture' are single-cycle pulses from the sequencer.
module sram_xfer_regs #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Freeze the request payload for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the memory data at the end of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= mem_dq_in;
        end
    end

endmodule

// File: rtl/sram_seq.sv
// Module: access sequencer. Walks read and write phases, reloads the
// phase timer and registers the strobes one-to-one from the next state,
// so the pins are glitch-free flops. Assumes all counts are at least 1.
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned RD_CYC    = 8,
    parameter int unsigned TURN_CYC  = 3,
    parameter int unsigned PULSE_CYC = 5,
    parameter int unsigned HOLD_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             capture,
    output logic             done_q,
    output pin_ctl_t         pins_q
);

    localparam logic [CNT_W-1:0] LD_RD    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);

    seq_state_t state_q, state_d;
    logic       last_rd_q;
    logic       finish;

    // Next-state, timer reload and handshake decode.
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && !done_q) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (!req_write) begin
                        state_d  = ST_RD;
                        load_val = LD_RD;
                    end else if (last_rd_q) begin
                        state_d  = ST_WTURN;
                        load_val = LD_TURN;
                    end else begin
                        state_d  = ST_WSETUP;
                    end
                end
            end
            ST_RD: begin
                if (expired) begin
                    state_d = ST_IDLE;
                    capture = 1'b1;
                    finish  = 1'b1;
                end
            end
            ST_WTURN: begin
                if (expired) begin
                    state_d = ST_WSETUP;
                    load    = 1'b1;
                end
            end
            ST_WSETUP: begin
                if (expired) begin
                    state_d  = ST_WPULSE;
                    load     = 1'b1;
                    load_val = LD_PULSE;
                end
            end
            ST_WPULSE: begin
                if (expired) begin
                    state_d  = ST_WHOLD;
                    load     = 1'b1;
                    load_val = LD_HOLD;
                end
            end
            ST_WHOLD: begin
                if (expired) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, previous-access kind, completion pulse and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b0;
            done_q    <= 1'b0;
            pins_q    <= PINS_IDLE;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            pins_q  <= pins_for(state_d);
            if (accept) begin
                last_rd_q <= !req_write;
            end
        end
    end

endmodule

// File: rtl/sram_ctl.sv
// Module: top of the asynchronous SRAM controller. Derives every phase
// length from the clock period and the memory's nanosecond limits, and
// wires sequencer, phase timer and transfer registers. Assumes the pad
// ring builds the tri-state data buffer from mem_dq_out/mem_dq_oe.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W         = 19,
    parameter int unsigned DATA_W         = 8,
    parameter int unsigned CLK_PS         = 8000,
    parameter int unsigned WE_PULSE_NS    = 40,
    parameter int unsigned DATA_SETUP_NS  = 25,
    parameter int unsigned SEL_TO_END_NS  = 45,
    parameter int unsigned WR_CYCLE_NS    = 55,
    parameter int unsigned ADDR_ACCESS_NS = 55,
    parameter int unsigned OE_ACCESS_NS   = 25,
    parameter int unsigned RELEASE_NS     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_rd_en_n,
    output logic              mem_wr_en_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned WP_CYC    = cyc_of(WE_PULSE_NS, CLK_PS);
    localparam int unsigned DW_CYC    = cyc_of(DATA_SETUP_NS, CLK_PS);
    localparam int unsigned SE_CYC    = cyc_of(SEL_TO_END_NS, CLK_PS);
    localparam int unsigned WC_CYC    = cyc_of(WR_CYCLE_NS, CLK_PS);
    localparam int unsigned AA_CYC    = cyc_of(ADDR_ACCESS_NS, CLK_PS) + 1;
    localparam int unsigned OA_CYC    = cyc_of(OE_ACCESS_NS, CLK_PS) + 1;
    localparam int unsigned RD_CYC    = umax(AA_CYC, OA_CYC);
    localparam int unsigned PULSE_CYC = umax(1, umax(umax(WP_CYC, DW_CYC), (SE_CYC > 1) ? SE_CYC - 1 : 0));
    localparam int unsigned HOLD_CYC  = umax(1, (WC_CYC > PULSE_CYC + 1) ? WC_CYC - PULSE_CYC - 1 : 0);
    localparam int unsigned TURN_CYC  = umax(1, cyc_of(RELEASE_NS, CLK_PS));
    localparam int unsigned MAX_CYC   = umax(umax(RD_CYC, PULSE_CYC), umax(HOLD_CYC, TURN_CYC));
    localparam int unsigned CNT_W     = umax(1, $clog2(MAX_CYC));

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             accept;
    logic             capture;
    pin_ctl_t         pins;

    sram_seq #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .accept   (accept),
        .capture  (capture),
        .done_q   (req_ready),
        .pins_q   (pins)
    );

    sram_phase_timer #(
        .CNT_W(CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .expired (expired)
    );

    sram_xfer_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .mem_dq_in(mem_dq_in),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out),
        .rdata_q  (req_rdata)
    );

    assign mem_sel_n   = pins.sel_n;
    assign mem_rd_en_n = pins.rd_en_n;
    assign mem_wr_en_n = pins.wr_en_n;
    assign mem_dq_oe   = pins.drive;

endmodule

// File: rtl/sram_ctl_chk.sv
// Module: protocol checker for the SRAM controller pins, bound to the top.
// Assumes PULSE_CYC matches the top's derived write-pulse length.
module sram_ctl_chk #(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PULSE_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_rd_en_n,
    input logic              mem_wr_en_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    logic [15:0] we_low_cnt;

    // Length of the current write-enable low run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
        end else if (!mem_wr_en_n) begin
            we_low_cnt <= we_low_cnt + 1'b1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    p_drive_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_rd_en_n);

    p_write_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_en_n |-> (mem_rd_en_n && !mem_sel_n && mem_dq_oe));

    p_drive_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_en_n) |-> $past(mem_dq_oe));

    p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en_n) |-> (we_low_cnt == 16'(PULSE_CYC)));

    p_hold_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en_n) |-> (mem_dq_oe && !mem_sel_n));

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

    p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_sel_n);

endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PULSE_CYC(PULSE_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_rd_en_n(mem_rd_en_n),
    .mem_wr_en_n(mem_wr_en_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctl_tb_top.sv
// Bench: directed scenarios against a behavioural SRAM model that enforces
// access time, write pulse, data setup and output release in clock cycles.
module sram_ctl_tb_top;

    localparam int CLK_PS = 8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  req_rdata;
    logic [18:0] mem_addr;
    logic        mem_sel_n, mem_rd_en_n, mem_wr_en_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // 125 MHz clock (8 ns period)
    always #4 clk = ~clk;

    sram_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_rd_en_n(mem_rd_en_n), .mem_wr_en_n(mem_wr_en_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [7:0] mem_m [logic [18:0]];
    int we_low = 0, drv_run = 0, oe_low = 0, tail = 0;
    logic [18:0] w_addr;
    logic [7:0]  w_data;

    always @(negedge clk) begin
        if (!rst_n) begin
            we_low = 0; drv_run = 0; oe_low = 0; tail = 0;
            mem_dq_in <= 8'hEE;
        end else begin
            // memory outputs still on while controller drives: contention
            if (mem_dq_oe && tail > 0) chk(1'b0, "R7 bus contention cycles", tail, 0);
            if (mem_dq_oe) drv_run++; else drv_run = 0;
            if (!mem_wr_en_n && !mem_sel_n) begin
                we_low++; w_addr = mem_addr; w_data = mem_dq_out;
            end else if (we_low > 0) begin
                chk(we_low * CLK_PS >= 40000, "R5 write pulse ps", we_low * CLK_PS, 40000);
                chk((drv_run - 1) * CLK_PS >= 25000, "R4 data setup ps", (drv_run - 1) * CLK_PS, 25000);
                mem_m[w_addr] = w_data;
                we_low = 0;
            end
            if (!mem_sel_n && !mem_rd_en_n && mem_wr_en_n) begin
                oe_low++; tail = 3;
            end else begin
                oe_low = 0;
                if (tail > 0) tail--;
            end
            if (oe_low > 0 && oe_low * CLK_PS - CLK_PS / 2 >= 55000)
                mem_dq_in <= mem_m.exists(mem_addr) ? mem_m[mem_addr] : 8'h00;
            else
                mem_dq_in <= 8'hEE;
        end
    end

    // ---------------- access tasks ----------------
    // Write; counts select-low, we-low, drive, lead and turnaround cycles.
    task automatic wr_op(input logic [18:0] a, input logic [7:0] d, input bit scramble,
                         input bit linger, output int n_sel, output int n_we, output int n_drv,
                         output int n_lead, output int n_turn, output bit oe_seen,
                         output bit moved);
        int guard = 0;
        bit seen_we = 0, seen_drv = 0, have = 0;
        logic [18:0] a0 = '0;
        logic [7:0] d0 = '0;
        n_sel = 0; n_we = 0; n_drv = 0; n_lead = 0; n_turn = 0; oe_seen = 0; moved = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        do begin
            @(negedge clk);
            guard++;
            if (scramble) begin req_addr = ~a; req_wdata = ~d; end
            if (!mem_sel_n) begin
                n_sel++;
                if (have && mem_addr != a0) moved = 1;
                a0 = mem_addr; have = 1;
            end
            if (!mem_wr_en_n) begin n_we++; seen_we = 1; end
            if (mem_dq_oe) begin
                if (seen_drv && mem_dq_out != d0) moved = 1;
                d0 = mem_dq_out;
                n_drv++; seen_drv = 1;
                if (!seen_we) n_lead++;
            end else if (!mem_sel_n && !seen_drv) begin
                n_turn++;
            end
            if (!mem_rd_en_n) oe_seen = 1;
        end while (!req_ready && guard < 60);
        chk(guard < 60, "R9 write completion cycles", guard, 8);
        if (linger) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R9 ready width (held valid)", int'(req_ready), 0);
            req_valid = 1'b0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(mem_sel_n == 1'b1, "R9 no re-accept in ready cycle", int'(mem_sel_n), 1);
            end
        end else begin
            req_valid = 1'b0;
            @(negedge clk);
            chk(req_ready == 1'b0, "R9 ready width", int'(req_ready), 0);
        end
    endtask

    // Read; counts select-low and read-enable-low cycles, returns data.
    task automatic rd_op(input logic [18:0] a, output int n_sel, output int n_oe,
                         output bit drv_seen, output logic [7:0] data);
        int guard = 0;
        n_sel = 0; n_oe = 0; drv_seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        do begin
            @(negedge clk);
            guard++;
            if (!mem_sel_n) n_sel++;
            if (!mem_rd_en_n && !mem_sel_n && mem_wr_en_n) n_oe++;
            if (mem_dq_oe) drv_seen = 1;
        end while (!req_ready && guard < 60);
        chk(guard < 60, "R9 read completion cycles", guard, 9);
        data = req_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 ready width", int'(req_ready), 0);
        chk(req_rdata == data, "R3 read data held", int'(req_rdata), int'(data));
    endtask

    task automatic simple_read(input logic [18:0] a, input logic [7:0] exp, input string tag);
        int s, o; bit dv; logic [7:0] q;
        rd_op(a, s, o, dv, q);
        chk(q == exp, tag, int'(q), int'(exp));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_sel_n === 1'b1, "R1 select idle", int'(mem_sel_n), 1);
        chk(mem_rd_en_n === 1'b1, "R1 read-enable idle", int'(mem_rd_en_n), 1);
        chk(mem_wr_en_n === 1'b1, "R1 write-enable idle", int'(mem_wr_en_n), 1);
        chk(mem_dq_oe === 1'b0, "R1 drive idle", int'(mem_dq_oe), 0);
        chk(req_ready === 1'b0, "R1 ready idle", int'(req_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_sel_n === 1'b1 && mem_dq_oe === 1'b0, "R1 idle after release", int'(mem_sel_n), 1);
    endtask

    task automatic t_first_write();
        int s, w, dv, ld, tn; bit oe, mv;
        wr_op(19'h00012, 8'hA5, 0, 0, s, w, dv, ld, tn, oe, mv);
        chk(tn == 0, "R7 no turnaround after reset/write", tn, 0);
        chk(s == 7, "R6 write select cycles", s, 7);
        chk(w == 5, "R5 write-enable low cycles", w, 5);
        chk(ld == 1, "R4 drive lead cycles", ld, 1);
        chk(dv - ld - w == 1, "R6 hold cycles", dv - ld - w, 1);
        chk(oe == 0, "R4 read-enable low during write", int'(oe), 0);
    endtask

    task automatic t_read_back();
        int s, o; bit dv; logic [7:0] q;
        rd_op(19'h00012, s, o, dv, q);
        chk(s == 8, "R2 read select cycles", s, 8);
        chk(o == 8, "R2 read-enable cycles", o, 8);
        chk(dv == 0, "R2 no drive during read", int'(dv), 0);
        chk(q == 8'hA5, "R3 read data", int'(q), 8'hA5);
    endtask

    task automatic t_write_after_read();
        int s, w, dv, ld, tn; bit oe, mv;
        wr_op(19'h7FFFF, 8'h3C, 0, 0, s, w, dv, ld, tn, oe, mv);
        chk(tn == 3, "R7 turnaround cycles", tn, 3);
        chk(s == 10, "R7 select cycles with turnaround", s, 10);
        chk(w == 5, "R5 write-enable low after read", w, 5);
        simple_read(19'h7FFFF, 8'h3C, "R10 top address data");
    endtask

    task automatic t_pattern();
        logic [18:0] addrs [4] = '{19'h00000, 19'h40000, 19'h12345, 19'h7FFFE};
        int s, w, dv, ld, tn; bit oe, mv;
        for (int i = 0; i < 4; i++)
            wr_op(addrs[i], 8'(8'h11 * (i + 3)), 0, 0, s, w, dv, ld, tn, oe, mv);
        for (int i = 0; i < 4; i++)
            simple_read(addrs[i], 8'(8'h11 * (i + 3)), "R10 pattern readback");
        simple_read(19'h7FFFF, 8'h3C, "R3 older data intact");
    endtask

    task automatic t_scramble();
        int s, w, dv, ld, tn; bit oe, mv;
        wr_op(19'h00100, 8'h5A, 1, 0, s, w, dv, ld, tn, oe, mv);
        chk(mv == 0, "R8 pins stable under input change", int'(mv), 0);
        simple_read(19'h00100, 8'h5A, "R8 captured payload written");
        simple_read(19'h7FEFF, 8'h00, "R8 changed address not written");
    endtask

    task automatic t_busy();
        int s, w, dv, ld, tn, extra = 0, guard = 0; bit oe, mv;
        // request held through the ready cycle must not restart
        wr_op(19'h00200, 8'hC3, 0, 1, s, w, dv, ld, tn, oe, mv);
        // request pulsed in the middle of an access must be dropped
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00200;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00300; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && guard < 60) begin @(negedge clk); guard++; end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!mem_sel_n) extra++;
        end
        chk(extra == 0, "R9 busy request ignored", extra, 0);
        simple_read(19'h00300, 8'h00, "R9 ignored write left memory");
        simple_read(19'h00200, 8'hC3, "R9 held-valid write done once");
    endtask

    initial begin
        t_reset();
        t_first_write();
        t_read_back();
        t_write_after_read();
        t_pattern();
        t_scramble();
        t_busy();
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL R9 watchdog: actual=hung expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule